// File: doc/BRIEF.md
# I2C Slave Receiver with Double-Buffered Data

This block is the receive half of an I2C bus slave. It samples the SCL and SDA lines into the system clock domain and finds start and stop conditions. After a start it collects a 7-bit address and a direction bit, and compares the address with a configured own address. If the address matches and the direction is write, it shifts in data bytes and acknowledges each one with a bit that the host supplies. Each finished byte goes into a receive buffer that the host reads through a strobe.

The block never stretches the clock. If the buffer is still full when a new byte completes, the new byte waits in a pending slot and moves into the buffer when the host reads. The host sees these flags: bus busy, direction, buffer full, interrupt and stop detected. It clears the interrupt and stop flags with single-cycle clear pulses. A stop condition can also raise the interrupt flag unless a mask input suppresses it.

Top module: `i2c_slave_rx`

## Requirements
- R1: A start condition (SDA falling while SCL is high) sets `busy_o` to 1 and restarts address reception.
- R2: The first 8 bits after a start are taken MSB first: 7 address bits, then the direction bit. On an address match, `xmit_o` takes the direction bit (0 = receive, 1 = transmit). The slave pulls SDA low during the 9th clock whatever the value of `ack_bit_i`, and at the 9th SCL rise it sets `irq_flag_o`. After a match with direction 1, the slave releases SDA and ignores the bus until the next start or stop.
- R3: If the address does not match, the slave does not drive SDA and sets neither the buffer-full flag nor the interrupt flag until the next start condition.
- R4: During the 9th clock of a data frame, `sda_pull_o` is 1 (SDA pulled low, ACK) exactly when `ack_bit_i` is 0.
- R5: At the 9th SCL rise of a data frame with an empty buffer, the byte appears on `rx_data_o`, and `full_o` and `irq_flag_o` become 1. `irq_o` is `irq_flag_o` gated by `irq_en_i`.
- R6: A `rd_stb_i` pulse with no byte pending clears `full_o`.
- R7: A byte that completes while the buffer is full waits in a pending slot. A newer byte overwrites an older pending byte. On the next `rd_stb_i` the pending byte moves to `rx_data_o`, and `full_o` and `irq_flag_o` are set again.
- R8: A stop condition (SDA rising while SCL is high) clears `busy_o` and sets `stop_flag_o`. It sets `irq_flag_o` only when `stop_irq_mask_i` is 0.
- R9: A start condition in the middle of a frame discards the partial bits, and the next 8 bits are taken as a fresh address frame.
- R10: `irq_clr_i` and `stop_clr_i` clear their flags. A hardware set in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| own_addr_i | input | ADDR_W | Slave address to match |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain drive) |
| ack_bit_i | input | 1 | Host acknowledge bit for data frames, 0 = ACK |
| irq_en_i | input | 1 | Interrupt output enable |
| stop_irq_mask_i | input | 1 | 1 keeps a stop from setting the interrupt flag |
| rd_stb_i | input | 1 | One-cycle read of the receive buffer |
| irq_clr_i | input | 1 | One-cycle clear of the interrupt flag |
| stop_clr_i | input | 1 | One-cycle clear of the stop flag |
| rx_data_o | output | ADDR_W+1 | Receive buffer contents |
| busy_o | output | 1 | Bus busy flag |
| xmit_o | output | 1 | Direction flag from the last matched address |
| full_o | output | 1 | Receive buffer full flag |
| irq_flag_o | output | 1 | Interrupt flag |
| stop_flag_o | output | 1 | Stop detected flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with `ADDR_W` = 7 and `SYNC_STAGES` = 3, and uses own address 0x5A. The longer synchronizer chain adds latency between each line change and the edge the frame logic sees. That exercises the ack window that opens and closes on detected SCL falls, and it shows whether a 16-cycle quarter bit period leaves enough margin. The bench sends a frame with no reads between bytes, so the pending slot fills and its move into the buffer on the next read can be observed. Cutting a frame after four bits shows how the block recovers from a start in the middle of a frame.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;

    typedef enum logic [1:0] {
        FR_IDLE,
        FR_ADDR,
        FR_DATA,
        FR_SKIP
    } fr_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } bus_evt_t;

endpackage

// File: rtl/i2c_rx_sync.sv
module i2c_rx_sync
    import i2c_rx_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt_o
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [STAGES-1:0] chain_d [LINES];
    logic [STAGES-1:0] chain_q [LINES];
    logic [LINES-1:0]  prev_d, prev_q, now_s;

    assign raw = {sda_i, scl_i};

    for (genvar ln = 0; ln < LINES; ln++) begin : g_line
        always_comb begin
            chain_d[ln] = {chain_q[ln][STAGES-2:0], raw[ln]};
            now_s[ln]   = chain_q[ln][STAGES-1];
            prev_d[ln]  = now_s[ln];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q[ln] <= '1;
                prev_q[ln]  <= 1'b1;
            end else begin
                chain_q[ln] <= chain_d[ln];
                prev_q[ln]  <= prev_d[ln];
            end
        end
    end

    always_comb begin
        evt_o.sda      = now_s[1];
        evt_o.scl_rise = now_s[0] & ~prev_q[0];
        evt_o.scl_fall = ~now_s[0] & prev_q[0];
        evt_o.start    = now_s[0] & prev_q[0] & prev_q[1] & ~now_s[1];
        evt_o.stop     = now_s[0] & prev_q[0] & ~prev_q[1] & now_s[1];
    end

endmodule

// File: rtl/i2c_rx_frame.sv
module i2c_rx_frame
    import i2c_rx_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_evt_t          evt_i,
    input  logic [ADDR_W-1:0] own_addr_i,
    input  logic              ack_bit_i,
    output logic              addr_stb_o,
    output logic              byte_stb_o,
    output logic [ADDR_W:0]   byte_o,
    output logic              xmit_o,
    output logic              pull_o,
    output logic              skip_o
);
    localparam int BYTE_W = ADDR_W + 1;
    localparam int CNT_W  = $clog2(BYTE_W + 2);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] HOLD_CNT = CNT_W'(BYTE_W + 1);

    typedef struct packed {
        fr_state_e         state;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] shift;
        logic              xmit;
        logic              ackwin;
        logic              ack_addr;
    } frame_t;

    frame_t fr_d, fr_q;
    logic [BYTE_W-1:0] shifted;

    always_comb begin
        fr_d       = fr_q;
        addr_stb_o = 1'b0;
        byte_stb_o = 1'b0;
        shifted    = {fr_q.shift[BYTE_W-2:0], evt_i.sda};

        if (evt_i.start) begin
            fr_d.state  = FR_ADDR;
            fr_d.cnt    = '0;
            fr_d.ackwin = 1'b0;
        end else if (evt_i.stop) begin
            fr_d.state  = FR_IDLE;
            fr_d.cnt    = '0;
            fr_d.ackwin = 1'b0;
        end else begin
            if (evt_i.scl_fall) begin
                if (fr_q.ackwin) begin
                    fr_d.ackwin = 1'b0;
                    if (fr_q.state == FR_ADDR) begin
                        fr_d.state = FR_SKIP;
                    end
                end else if (fr_q.cnt == ACK_BIT &&
                             (fr_q.state == FR_ADDR || fr_q.state == FR_DATA)) begin
                    fr_d.ackwin   = 1'b1;
                    fr_d.ack_addr = (fr_q.state == FR_ADDR);
                end
            end
            if (evt_i.scl_rise && (fr_q.state == FR_ADDR || fr_q.state == FR_DATA)) begin
                if (fr_q.cnt < ACK_BIT) begin
                    fr_d.shift = shifted;
                    fr_d.cnt   = fr_q.cnt + 1'b1;
                    if (fr_q.state == FR_ADDR && fr_q.cnt == LAST_BIT) begin
                        if (shifted[BYTE_W-1:1] == own_addr_i) begin
                            fr_d.xmit = shifted[0];
                        end else begin
                            fr_d.state = FR_SKIP;
                            fr_d.cnt   = '0;
                        end
                    end
                end else if (fr_q.cnt == ACK_BIT) begin
                    if (fr_q.state == FR_ADDR) begin
                        addr_stb_o = 1'b1;
                        if (fr_q.xmit) begin
                            fr_d.cnt = HOLD_CNT;
                        end else begin
                            fr_d.state = FR_DATA;
                            fr_d.cnt   = '0;
                        end
                    end else begin
                        byte_stb_o = 1'b1;
                        fr_d.cnt   = '0;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fr_q <= '{state: FR_IDLE, cnt: '0, shift: '0, xmit: 1'b0,
                      ackwin: 1'b0, ack_addr: 1'b0};
        end else begin
            fr_q <= fr_d;
        end
    end

    assign byte_o = fr_q.shift;
    assign xmit_o = fr_q.xmit;
    assign pull_o = fr_q.ackwin & (fr_q.ack_addr | ~ack_bit_i);
    assign skip_o = (fr_q.state == FR_SKIP);

endmodule

// File: rtl/i2c_rx_hostbuf.sv
module i2c_rx_hostbuf #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              addr_stb_i,
    input  logic              byte_stb_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              stop_mask_i,
    input  logic              rd_stb_i,
    input  logic              irq_clr_i,
    input  logic              stop_clr_i,
    output logic [BYTE_W-1:0] buf_o,
    output logic              full_o,
    output logic              irq_o,
    output logic              stop_o,
    output logic              busy_o,
    output logic              irq_set_o
);
    typedef struct packed {
        logic [BYTE_W-1:0] rbuf;
        logic [BYTE_W-1:0] pend;
        logic              pend_v;
        logic              full;
        logic              irq;
        logic              stop;
        logic              busy;
    } host_t;

    host_t hs_d, hs_q;
    logic  irq_set;

    always_comb begin
        hs_d    = hs_q;
        irq_set = 1'b0;

        if (irq_clr_i)  hs_d.irq  = 1'b0;
        if (stop_clr_i) hs_d.stop = 1'b0;

        if (start_i) hs_d.busy = 1'b1;
        if (stop_i) begin
            hs_d.busy = 1'b0;
            hs_d.stop = 1'b1;
            if (!stop_mask_i) irq_set = 1'b1;
        end
        if (addr_stb_i) irq_set = 1'b1;

        if (rd_stb_i) begin
            if (hs_q.pend_v) begin
                hs_d.rbuf   = hs_q.pend;
                hs_d.pend_v = 1'b0;
                hs_d.full   = 1'b1;
                irq_set     = 1'b1;
            end else begin
                hs_d.full = 1'b0;
            end
        end

        if (byte_stb_i) begin
            if (!hs_d.full) begin
                hs_d.rbuf = byte_i;
                hs_d.full = 1'b1;
            end else begin
                hs_d.pend   = byte_i;
                hs_d.pend_v = 1'b1;
            end
            irq_set = 1'b1;
        end

        if (irq_set) hs_d.irq = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_q <= '0;
        end else begin
            hs_q <= hs_d;
        end
    end

    assign buf_o     = hs_q.rbuf;
    assign full_o    = hs_q.full;
    assign irq_o     = hs_q.irq;
    assign stop_o    = hs_q.stop;
    assign busy_o    = hs_q.busy;
    assign irq_set_o = irq_set;

endmodule

// File: rtl/i2c_slave_rx.sv
module i2c_slave_rx
    import i2c_rx_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] own_addr_i,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_pull_o,
    input  logic              ack_bit_i,
    input  logic              irq_en_i,
    input  logic              stop_irq_mask_i,
    input  logic              rd_stb_i,
    input  logic              irq_clr_i,
    input  logic              stop_clr_i,
    output logic [ADDR_W:0]   rx_data_o,
    output logic              busy_o,
    output logic              xmit_o,
    output logic              full_o,
    output logic              irq_flag_o,
    output logic              stop_flag_o,
    output logic              irq_o
);
    localparam int BYTE_W = ADDR_W + 1;

    bus_evt_t          evt;
    logic              start_w, stop_w, addr_stb_w, byte_stb_w;
    logic              irq_set_w, skip_w;
    logic [BYTE_W-1:0] byte_w;

    i2c_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt_o (evt)
    );

    assign start_w = evt.start;
    assign stop_w  = evt.stop;

    i2c_rx_frame #(.ADDR_W(ADDR_W)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt),
        .own_addr_i (own_addr_i),
        .ack_bit_i  (ack_bit_i),
        .addr_stb_o (addr_stb_w),
        .byte_stb_o (byte_stb_w),
        .byte_o     (byte_w),
        .xmit_o     (xmit_o),
        .pull_o     (sda_pull_o),
        .skip_o     (skip_w)
    );

    i2c_rx_hostbuf #(.BYTE_W(BYTE_W)) u_host (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_w),
        .stop_i      (stop_w),
        .addr_stb_i  (addr_stb_w),
        .byte_stb_i  (byte_stb_w),
        .byte_i      (byte_w),
        .stop_mask_i (stop_irq_mask_i),
        .rd_stb_i    (rd_stb_i),
        .irq_clr_i   (irq_clr_i),
        .stop_clr_i  (stop_clr_i),
        .buf_o       (rx_data_o),
        .full_o      (full_o),
        .irq_o       (irq_flag_o),
        .stop_o      (stop_flag_o),
        .busy_o      (busy_o),
        .irq_set_o   (irq_set_w)
    );

    assign irq_o = irq_flag_o & irq_en_i;

endmodule

// File: rtl/i2c_slave_rx_chk.sv
module i2c_slave_rx_chk (
    input logic clk,
    input logic rst_n,
    input logic start_evt,
    input logic stop_evt,
    input logic byte_stb,
    input logic irq_set,
    input logic irq_clr,
    input logic skip,
    input logic pull,
    input logic busy,
    input logic full,
    input logic irq_flag,
    input logic stop_flag
);
    assert_busy_on_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> busy);

    assert_quiet_when_skipping_R3: assert property (@(posedge clk) disable iff (!rst_n)
        skip |-> !pull);

    assert_byte_fills_buffer_R5: assert property (@(posedge clk) disable iff (!rst_n)
        byte_stb |=> (full && irq_flag));

    assert_stop_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> (!busy && stop_flag));

    assert_set_beats_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_set && irq_clr) |=> irq_flag);

endmodule

bind i2c_slave_rx i2c_slave_rx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_evt (start_w),
    .stop_evt  (stop_w),
    .byte_stb  (byte_stb_w),
    .irq_set   (irq_set_w),
    .irq_clr   (irq_clr_i),
    .skip      (skip_w),
    .pull      (sda_pull_o),
    .busy      (busy_o),
    .full      (full_o),
    .irq_flag  (irq_flag_o),
    .stop_flag (stop_flag_o)
);

// File: tb/test_i2c_slave_rx.sv
`timescale 1ns/1ps
module test_i2c_slave_rx;
    localparam int AW = 7;
    localparam int Q  = 16;
    localparam logic [AW-1:0] OWN = 7'h5A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic sda_line;
    logic sda_pull;
    logic ack_bit = 1'b0, irq_en = 1'b1, stop_mask = 1'b0;
    logic rd_stb = 1'b0, irq_clr = 1'b0, stop_clr = 1'b0;
    logic [AW:0] rx_data;
    logic busy, xmit, full, irq_flag, stop_flag, irq;
    int n_chk = 0, n_bad = 0;

    always #2 clk = ~clk;

    assign sda_line = sda_m & ~sda_pull;

    i2c_slave_rx #(.ADDR_W(AW), .SYNC_STAGES(3)) i_i2c_slave_rx (
        .clk(clk), .rst_n(rst_n), .own_addr_i(OWN),
        .scl_i(scl_m), .sda_i(sda_line), .sda_pull_o(sda_pull),
        .ack_bit_i(ack_bit), .irq_en_i(irq_en), .stop_irq_mask_i(stop_mask),
        .rd_stb_i(rd_stb), .irq_clr_i(irq_clr), .stop_clr_i(stop_clr),
        .rx_data_o(rx_data), .busy_o(busy), .xmit_o(xmit), .full_o(full),
        .irq_flag_o(irq_flag), .stop_flag_o(stop_flag), .irq_o(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; hold(Q);
        scl_m = 1'b1; hold(Q);
        sda_m = 1'b0; hold(Q);
        scl_m = 1'b0; hold(Q);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; hold(Q);
        scl_m = 1'b1; hold(Q);
        sda_m = 1'b1; hold(Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; hold(Q);
            scl_m = 1'b1; hold(Q);
            scl_m = 1'b0; hold(Q);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        sda_m = 1'b1; hold(Q);
        scl_m = 1'b1; hold(Q / 2);
        ack = sda_line;
        hold(Q / 2);
        scl_m = 1'b0; hold(Q);
    endtask

    task automatic pulse_rd;
        rd_stb = 1'b1; hold(1); rd_stb = 1'b0; hold(2);
    endtask

    task automatic pulse_clr;
        irq_clr = 1'b1; stop_clr = 1'b1; hold(1);
        irq_clr = 1'b0; stop_clr = 1'b0; hold(2);
    endtask

    task automatic t_reset;
        chk("R1 reset busy", busy, 0);
        chk("R5 reset full", full, 0);
        chk("R5 reset irq flag", irq_flag, 0);
        chk("R8 reset stop flag", stop_flag, 0);
        chk("R4 reset pull", sda_pull, 0);
    endtask

    task automatic t_write_frame;
        logic a;
        bus_start;
        chk("R1 busy after start", busy, 1);
        send_byte({OWN, 1'b0}, a);
        chk("R2 address ack", a, 0);
        chk("R2 xmit cleared", xmit, 0);
        chk("R2 irq on address", irq_flag, 1);
        pulse_clr;
        chk("R10 irq cleared", irq_flag, 0);
        ack_bit = 1'b0;
        send_byte(8'hA5, a);
        chk("R4 data ack with ack bit 0", a, 0);
        chk("R5 full", full, 1);
        chk("R5 data", rx_data, 8'hA5);
        chk("R5 irq flag", irq_flag, 1);
        chk("R5 irq output enabled", irq, 1);
        irq_en = 1'b0; hold(1);
        chk("R5 irq output disabled", irq, 0);
        irq_en = 1'b1;
        pulse_rd;
        chk("R6 read clears full", full, 0);
        pulse_clr;
        ack_bit = 1'b1;
        send_byte(8'h3C, a);
        chk("R4 data nack with ack bit 1", a, 1);
        chk("R5 second data", rx_data, 8'h3C);
        pulse_rd;
        pulse_clr;
        ack_bit = 1'b0;
        stop_mask = 1'b0;
        bus_stop;
        chk("R8 busy cleared", busy, 0);
        chk("R8 stop flag", stop_flag, 1);
        chk("R8 irq on unmasked stop", irq_flag, 1);
        pulse_clr;
        chk("R10 stop flag cleared", stop_flag, 0);
        chk("R10 irq cleared after stop", irq_flag, 0);
    endtask

    task automatic t_double;
        logic a;
        bus_start;
        send_byte({OWN, 1'b0}, a);
        pulse_clr;
        send_byte(8'h11, a);
        send_byte(8'h22, a);
        send_byte(8'h33, a);
        chk("R7 buffer keeps first", rx_data, 8'h11);
        chk("R7 full", full, 1);
        pulse_clr;
        pulse_rd;
        chk("R7 newest pending moved", rx_data, 8'h33);
        chk("R7 full again", full, 1);
        chk("R7 irq again", irq_flag, 1);
        pulse_rd;
        chk("R6 buffer drained", full, 0);
        pulse_clr;
        stop_mask = 1'b1;
        bus_stop;
        chk("R8 masked stop keeps irq low", irq_flag, 0);
        chk("R8 masked stop flag", stop_flag, 1);
        stop_mask = 1'b0;
        pulse_clr;
    endtask

    task automatic t_mismatch;
        logic a;
        bus_start;
        send_byte({OWN ^ 7'h01, 1'b0}, a);
        chk("R3 no address ack", a, 1);
        chk("R3 no irq", irq_flag, 0);
        send_byte(8'h55, a);
        chk("R3 no data ack", a, 1);
        chk("R3 buffer untouched", full, 0);
        bus_stop;
        pulse_clr;
    endtask

    task automatic t_read_dir;
        logic a;
        bus_start;
        send_byte({OWN, 1'b1}, a);
        chk("R2 read address ack", a, 0);
        chk("R2 xmit set", xmit, 1);
        chk("R2 bus released after ack", sda_pull, 0);
        send_byte(8'h00, a);
        chk("R2 ignored after read match", a, 1);
        chk("R2 no byte stored", full, 0);
        bus_stop;
        pulse_clr;
    endtask

    task automatic t_restart;
        logic a;
        bus_start;
        send_bits(8'hF0, 4);
        bus_start;
        send_byte({OWN, 1'b0}, a);
        chk("R9 address after restart", a, 0);
        chk("R9 xmit after restart", xmit, 0);
        pulse_clr;
        send_byte(8'h7E, a);
        chk("R9 data after restart", rx_data, 8'h7E);
        pulse_rd;
        bus_stop;
        pulse_clr;
    endtask

    initial begin
        hold(5);
        rst_n = 1'b1;
        hold(5);
        t_reset;
        t_write_frame;
        t_double;
        t_mismatch;
        t_read_dir;
        t_restart;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule